// File: doc/BRIEF.md
# Aggressive Link Power Controller

This block sits beside a storage host port and decides when the serial link may drop into a low-power state. It watches the command-issue bitmap, the queued-tag bitmap and a pulse that marks a completion clear made by the controller itself. When such a clear leaves both bitmaps at zero and aggressive power management is enabled, it asks the PHY for Partial or Slumber. Which of the two it asks for comes from a software select bit, which a capability strap can override.

While the link rests in Partial, a programmable idle counter can later move it on to Slumber, if that step is enabled and the strap allows it. A new command bit that appears while the link is asleep, or while a sleep request is still pending, raises a request to return to active. No further sleep request leaves the block until the PHY has acknowledged that return.

Requests to the PHY form a single valid/ready channel. `phy_req_vld` rises together with a target in `phy_req_state`. Both hold steady until `phy_ack` is seen high on a clock edge, and only one request is ever outstanding. An acknowledge that arrives while no request is valid is ignored. The reported link state changes only on the edge that accepts the acknowledge.

Top module: `lpm_aggr_ctrl`

## Requirements
- R1: After reset `link_state` is 2'b00 (active) and `phy_req_vld` is 0.
- R2: While `cfg_aggr_en` is 0, no request is raised from the active state.
- R3: A request is raised only on a cycle where `hw_clr` is 1 and both bitmaps are zero. A `hw_clr` with either bitmap non-zero, or bitmaps that reach zero without `hw_clr`, raise nothing. The request is visible one cycle after the triggering edge.
- R4: With the strap `cap_aggr_sel` at 1, `cfg_slumber_sel` at 1 selects target 2'b10 (Slumber) and 0 selects target 2'b01 (Partial).
- R5: With `cap_aggr_sel` at 0, the target of an idle-entry request is always 2'b01, whatever `cfg_slumber_sel` holds.
- R6: `phy_req_vld` and `phy_req_state` hold stable until accepted by `phy_ack`. At most one request is outstanding. `link_state` changes only on an accepting edge.
- R7: `link_state` reports 2'b00 active, 2'b01 partial, 2'b10 slumber, and never 2'b11.
- R8: In Partial with both `cfg_p2s_en` and `cap_p2s` at 1, a Slumber request (2'b10) is raised `cfg_p2s_idle`+1 cycles after the edge that entered Partial. If either bit is 0, no such request is raised.
- R9: A bit newly set in `issue_map` while the link is in Partial or Slumber, or while a sleep request is pending, raises a request with target 2'b00. From a settled low-power state this happens one cycle later; a bit seen during a pending request is remembered and served once that request is accepted.
- R10: While the link is not active, or while any request is pending, idle triggers raise no new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_map | input | NSLOT | Command-issue bitmap |
| queued_map | input | NSLOT | Queued-tag bitmap |
| hw_clr | input | 1 | Pulse: controller cleared a bit in a bitmap this cycle |
| cfg_aggr_en | input | 1 | Aggressive power management enable |
| cfg_slumber_sel | input | 1 | 1 selects Slumber, 0 selects Partial |
| cfg_p2s_en | input | 1 | Partial-to-Slumber enable |
| cap_aggr_sel | input | 1 | Strap: select bit honoured |
| cap_p2s | input | 1 | Strap: Partial-to-Slumber honoured |
| cfg_p2s_idle | input | CNTW | Idle cycles in Partial before Slumber request |
| phy_req_vld | output | 1 | Request valid |
| phy_req_state | output | 2 | Requested link state |
| phy_ack | input | 1 | PHY accepts the request |
| link_state | output | 2 | Current link power state |

## Verification
An idle-entry request is due one cycle after the edge that sees the trigger, and a wake request from a settled low-power state is due one cycle after the edge that sees the new command bit. The reported state moves on the accepting edge, and a Partial-to-Slumber request comes `cfg_p2s_idle`+1 edges after Partial was entered. The bench drives inputs on the falling edge and reads outputs on the following falling edge, so every check lands after exactly the register stages counted above. The Partial-to-Slumber delay is measured by counting falling edges from the first one that shows Partial. A monitor compares each new request against the next expected target that the driver queued.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    LS_ACTIVE  = 2'b00,
    LS_PARTIAL = 2'b01,
    LS_SLUMBER = 2'b10
  } lstate_t;
endpackage

// File: rtl/lpm_idle_detect.sv
module lpm_idle_detect #(
  parameter int NSLOT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] issue_map,
  input  logic [NSLOT-1:0] queued_map,
  input  logic             hw_clr,
  output logic             idle_trig,
  output logic             new_cmd
);
  logic [NSLOT-1:0] issue_q;

  always_ff @(posedge clk) begin
    if (!rst_n) issue_q <= '0;
    else        issue_q <= issue_map;
  end

  // only a completion clear that empties both maps counts
  assign idle_trig = hw_clr && (issue_map == '0) && (queued_map == '0);
  assign new_cmd   = |(issue_map & ~issue_q);
endmodule

// File: rtl/lpm_cap_mask.sv
module lpm_cap_mask (
  input  logic cfg_slumber_sel,
  input  logic cfg_p2s_en,
  input  logic cap_aggr_sel,
  input  logic cap_p2s,
  output logic sel_slumber,
  output logic p2s_ok
);
  assign sel_slumber = cfg_slumber_sel & cap_aggr_sel;
  assign p2s_ok      = cfg_p2s_en & cap_p2s;
endmodule

// File: rtl/lpm_p2s_timer.sv
module lpm_p2s_timer #(
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [CNTW-1:0] limit,
  output logic            fire
);
  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt != limit) cnt <= cnt + 1'b1;
  end

  assign fire = run && (cnt == limit);
endmodule

// File: rtl/lpm_req_fsm.sv
module lpm_req_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_trig,
  input  logic       new_cmd,
  input  logic       aggr_en,
  input  logic       sel_slumber,
  input  logic       p2s_fire,
  input  logic       phy_ack,
  output logic       req_vld,
  output lstate_t    req_tgt,
  output lstate_t    link_st,
  output logic       wake_pend
);
  logic    wake_need;
  logic    waking;
  assign wake_need = wake_pend | new_cmd;
  assign waking    = req_vld && (req_tgt == LS_ACTIVE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_vld   <= 1'b0;
      req_tgt   <= LS_ACTIVE;
      link_st   <= LS_ACTIVE;
      wake_pend <= 1'b0;
    end else if (req_vld) begin
      if (new_cmd && !waking) wake_pend <= 1'b1;
      if (phy_ack) begin
        link_st <= req_tgt;
        req_vld <= 1'b0;
        if (req_tgt == LS_ACTIVE) wake_pend <= 1'b0;
      end
    end else if (link_st != LS_ACTIVE) begin
      if (wake_need) begin
        req_vld   <= 1'b1;
        req_tgt   <= LS_ACTIVE;
        wake_pend <= 1'b0;
      end else if (link_st == LS_PARTIAL && p2s_fire) begin
        req_vld <= 1'b1;
        req_tgt <= LS_SLUMBER;
      end
    end else if (idle_trig && aggr_en) begin
      req_vld <= 1'b1;
      req_tgt <= sel_slumber ? LS_SLUMBER : LS_PARTIAL;
    end
  end
endmodule

// File: rtl/lpm_aggr_ctrl.sv
module lpm_aggr_ctrl
  import lpm_pkg::*;
#(
  parameter int NSLOT = 32,
  parameter int CNTW  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] issue_map,
  input  logic [NSLOT-1:0] queued_map,
  input  logic             hw_clr,
  input  logic             cfg_aggr_en,
  input  logic             cfg_slumber_sel,
  input  logic             cfg_p2s_en,
  input  logic             cap_aggr_sel,
  input  logic             cap_p2s,
  input  logic [CNTW-1:0]  cfg_p2s_idle,
  output logic             phy_req_vld,
  output logic [1:0]       phy_req_state,
  input  logic             phy_ack,
  output logic [1:0]       link_state
);
  logic    idle_trig, new_cmd, sel_slumber, p2s_ok, p2s_fire, p2s_run;
  logic    req_vld, wake_pend;
  lstate_t req_tgt, link_st;

  lpm_idle_detect #(.NSLOT(NSLOT)) u_detect (
    .clk(clk), .rst_n(rst_n), .issue_map(issue_map), .queued_map(queued_map),
    .hw_clr(hw_clr), .idle_trig(idle_trig), .new_cmd(new_cmd)
  );

  lpm_cap_mask u_mask (
    .cfg_slumber_sel(cfg_slumber_sel), .cfg_p2s_en(cfg_p2s_en),
    .cap_aggr_sel(cap_aggr_sel), .cap_p2s(cap_p2s),
    .sel_slumber(sel_slumber), .p2s_ok(p2s_ok)
  );

  assign p2s_run = (link_st == LS_PARTIAL) && !req_vld && p2s_ok
                   && !wake_pend && !new_cmd;

  lpm_p2s_timer #(.CNTW(CNTW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(p2s_run), .limit(cfg_p2s_idle),
    .fire(p2s_fire)
  );

  lpm_req_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .idle_trig(idle_trig), .new_cmd(new_cmd),
    .aggr_en(cfg_aggr_en), .sel_slumber(sel_slumber), .p2s_fire(p2s_fire),
    .phy_ack(phy_ack), .req_vld(req_vld), .req_tgt(req_tgt),
    .link_st(link_st), .wake_pend(wake_pend)
  );

  assign phy_req_vld   = req_vld;
  assign phy_req_state = req_tgt;
  assign link_state    = link_st;
endmodule

// File: rtl/lpm_aggr_ctrl_chk.sv
module lpm_aggr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hw_clr,
  input logic       cfg_aggr_en,
  input logic       cap_aggr_sel,
  input logic       cfg_p2s_en,
  input logic       cap_p2s,
  input logic       phy_req_vld,
  input logic [1:0] phy_req_state,
  input logic       phy_ack,
  input logic [1:0] link_state
);
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req_vld && !phy_ack |=> phy_req_vld && $stable(phy_req_state));

  assert_state_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(phy_req_vld && phy_ack) |=> $stable(link_state));

  assert_encoding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_state != 2'b11);

  assert_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_aggr_en && link_state == 2'b00 && !phy_req_vld |=> !phy_req_vld);

  assert_trigger_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_clr && link_state == 2'b00 && !phy_req_vld |=> !phy_req_vld);

  assert_cap_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_aggr_sel && link_state == 2'b00 && !phy_req_vld
    |=> !(phy_req_vld && phy_req_state == 2'b10));

  assert_p2s_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_p2s_en && cap_p2s) && link_state == 2'b01 && !phy_req_vld
    |=> !(phy_req_vld && phy_req_state == 2'b10));

  assert_wake_from_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req_vld && phy_req_state == 2'b00 |-> link_state != 2'b00);

  assert_no_deeper_R10: assert property (@(posedge clk) disable iff (!rst_n)
    link_state == 2'b10 && phy_req_vld |-> phy_req_state == 2'b00);
endmodule

bind lpm_aggr_ctrl lpm_aggr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hw_clr(hw_clr), .cfg_aggr_en(cfg_aggr_en),
  .cap_aggr_sel(cap_aggr_sel), .cfg_p2s_en(cfg_p2s_en), .cap_p2s(cap_p2s),
  .phy_req_vld(phy_req_vld), .phy_req_state(phy_req_state),
  .phy_ack(phy_ack), .link_state(link_state)
);

// File: tb/lpm_aggr_ctrl_test.sv
module lpm_aggr_ctrl_test;
  localparam int NSLOT = 32;
  localparam int CNTW  = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NSLOT-1:0] issue_map = '0, queued_map = '0;
  logic             hw_clr = 1'b0, cfg_aggr_en = 1'b0, cfg_slumber_sel = 1'b0;
  logic             cfg_p2s_en = 1'b0, cap_aggr_sel = 1'b0, cap_p2s = 1'b0;
  logic [CNTW-1:0]  cfg_p2s_idle = '0;
  logic             phy_req_vld, phy_ack = 1'b0;
  logic [1:0]       phy_req_state, link_state;

  always #10 clk = ~clk;

  lpm_aggr_ctrl #(.NSLOT(NSLOT), .CNTW(CNTW)) uut (
    .clk(clk), .rst_n(rst_n), .issue_map(issue_map), .queued_map(queued_map),
    .hw_clr(hw_clr), .cfg_aggr_en(cfg_aggr_en), .cfg_slumber_sel(cfg_slumber_sel),
    .cfg_p2s_en(cfg_p2s_en), .cap_aggr_sel(cap_aggr_sel), .cap_p2s(cap_p2s),
    .cfg_p2s_idle(cfg_p2s_idle), .phy_req_vld(phy_req_vld),
    .phy_req_state(phy_req_state), .phy_ack(phy_ack), .link_state(link_state)
  );

  // scoreboard storage: driver writes, monitor reads
  logic [1:0] exp_mem [0:63];
  int wr_ptr = 0, rd_ptr = 0;
  int nchk = 0, nbad = 0, mchk = 0, mbad = 0, wbad = 0;
  logic auto_ack = 1'b1, man_go = 1'b0;
  int ack_lat = 2;

  // PHY model
  int acnt = 0;
  always @(negedge clk) begin
    if (phy_ack) begin
      phy_ack <= 1'b0; acnt = 0;
    end else if (phy_req_vld) begin
      if (man_go || (auto_ack && acnt >= ack_lat)) phy_ack <= 1'b1;
      else acnt = acnt + 1;
    end else acnt = 0;
  end

  // monitor
  initial begin
    logic prev_vld;
    prev_vld = 1'b0;
    forever begin
      @(negedge clk); #2;
      if (rst_n && phy_req_vld && !prev_vld) begin
        mchk++;
        if (rd_ptr == wr_ptr) begin
          mbad++;
          $display("FAIL R10 unexpected request actual=%0d expected=none", phy_req_state);
        end else begin
          if (phy_req_state != exp_mem[rd_ptr]) begin
            mbad++;
            $display("FAIL R4 request target actual=%0d expected=%0d",
                     phy_req_state, exp_mem[rd_ptr]);
          end
          rd_ptr++;
        end
      end
      prev_vld = phy_req_vld;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_req(input logic [1:0] t);
    exp_mem[wr_ptr] = t;
    wr_ptr++;
  endtask

  task automatic trig();
    issue_map = '0; queued_map = '0; hw_clr = 1'b1;
    step(1);
    hw_clr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40; i++) begin
      if (!phy_req_vld && !phy_ack) break;
      step(1);
    end
  endtask

  task automatic man_ack();
    man_go = 1'b1;
    step(2);
    man_go = 1'b0;
  endtask

  task automatic wake();
    expect_req(2'b00);
    issue_map = 32'h1;
    step(1);
    chk(phy_req_vld && phy_req_state == 2'b00, "R9 wake", phy_req_state, 0);
    wait_idle();
    chk(link_state == 2'b00, "R9 back to active", link_state, 0);
    issue_map = '0;
    step(1);
  endtask

  initial begin
    int n;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk(link_state == 2'b00, "R1 state", link_state, 0);
    chk(!phy_req_vld, "R1 no request", phy_req_vld, 0);

    // R2: disabled
    issue_map = 32'h4; step(1);
    trig();
    chk(!phy_req_vld, "R2 disabled", phy_req_vld, 0);
    step(4);
    chk(!phy_req_vld && link_state == 2'b00, "R2 disabled later", phy_req_vld, 0);

    // R3 and R6: partial entry, held without ack
    cfg_aggr_en = 1'b1; cap_aggr_sel = 1'b1; cfg_slumber_sel = 1'b0;
    auto_ack = 1'b0;
    expect_req(2'b01);
    trig();
    chk(phy_req_vld && phy_req_state == 2'b01, "R3 request raised", phy_req_state, 1);
    step(4);
    chk(phy_req_vld && phy_req_state == 2'b01, "R6 held", phy_req_state, 1);
    chk(link_state == 2'b00, "R6 no state change before ack", link_state, 0);
    man_ack();
    chk(link_state == 2'b01, "R7 partial code", link_state, 1);
    chk(!phy_req_vld, "R6 released", phy_req_vld, 0);
    auto_ack = 1'b1;
    wake();

    // R3: clears that do not qualify
    issue_map = '0; queued_map = 32'h8; hw_clr = 1'b1;
    step(1);
    hw_clr = 1'b0;
    chk(!phy_req_vld, "R3 queued nonzero", phy_req_vld, 0);
    queued_map = '0;
    step(3);
    chk(!phy_req_vld, "R3 zero without clear", phy_req_vld, 0);

    // R4: slumber select
    cfg_slumber_sel = 1'b1;
    expect_req(2'b10);
    trig();
    chk(phy_req_vld && phy_req_state == 2'b10, "R4 slumber", phy_req_state, 2);
    wait_idle();
    chk(link_state == 2'b10, "R7 slumber code", link_state, 2);
    wake();

    // R5 and R8 gate: strap off
    cap_aggr_sel = 1'b0; cfg_p2s_en = 1'b1; cap_p2s = 1'b0; cfg_p2s_idle = 16'd3;
    expect_req(2'b01);
    trig();
    chk(phy_req_vld && phy_req_state == 2'b01, "R5 masked select", phy_req_state, 1);
    wait_idle();
    step(20);
    chk(!phy_req_vld && link_state == 2'b01, "R8 strap blocks", link_state, 1);
    trig();
    step(2);
    chk(!phy_req_vld && link_state == 2'b01, "R10 no trigger while partial", phy_req_vld, 0);
    wake();

    // R8: timed partial to slumber
    cap_p2s = 1'b1; cfg_p2s_idle = 16'd5;
    expect_req(2'b01);
    expect_req(2'b10);
    trig();
    for (int i = 0; i < 20 && link_state != 2'b01; i++) step(1);
    n = 0;
    for (int i = 0; i < 40 && !phy_req_vld; i++) begin step(1); n++; end
    chk(n == 6, "R8 idle delay", n, 6);
    chk(phy_req_state == 2'b10, "R8 target", phy_req_state, 2);
    wait_idle();
    chk(link_state == 2'b10, "R8 reached slumber", link_state, 2);
    wake();

    // R10 and R9: trigger and new command while pending
    cap_p2s = 1'b0; auto_ack = 1'b0;
    expect_req(2'b01);
    trig();
    trig();
    chk(phy_req_vld && phy_req_state == 2'b01, "R10 single outstanding", phy_req_state, 1);
    expect_req(2'b00);
    issue_map = 32'h2;
    step(1);
    man_ack();
    for (int i = 0; i < 3 && !phy_req_vld; i++) step(1);
    chk(phy_req_vld && phy_req_state == 2'b00, "R9 latched wake", phy_req_state, 0);
    man_ack();
    chk(link_state == 2'b00, "R9 latched wake done", link_state, 0);

    step(5);
    chk(rd_ptr == wr_ptr, "R6 all expected requests seen", rd_ptr, wr_ptr);
    $display("test done: total=%0d bad=%0d", nchk + mchk, nbad + mbad + wbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    wbad = 1;
    $display("FAIL R6 watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", nchk + mchk + 1, nbad + mbad + wbad);
    $finish;
  end
endmodule